// File: doc/BRIEF.md
# Fixed-Period Fan PWM Controller

This block generates a single active-high pulse-width-modulated signal for a two-wire fan. Software programs it through a small bank of 32-bit registers with a plain read/write port: an address, a write strobe, write data and combinational read data. The pulse repeats with a fixed period of `CLK_HZ * PERIOD_MS / 1000` clock cycles. That period is a build-time parameter and cannot be changed from the registers. The high part of each period is proportional to an 8-bit duty code. Code 0 keeps the pin low, and code 255 keeps it high for the whole period.

Clearing the run bit forces the pin low and throws away the position inside the period, so the next run starts a fresh period. Duty writes are not shadowed. A new code takes effect on the very next cycle, even in the middle of a period. A maximum-speed field and a mode bit are stored and read back. In the two-wire configuration built here, neither one changes the output. Every port is a plain control or status pin, so the block has no stream interface and no back-pressure.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, both registers read 0 and `pwm_o` is 0.
- R2: The control word sits at byte offset 0x0. Bit 0 is run (1 = run), bit 1 is mode, and bits 23:16 hold the duty code. All other bits read 0 and ignore writes.
- R3: The limit word sits at byte offset 0x4, with the maximum-speed value in bits 15:0 and bits 31:16 reading 0. Any other word address reads 0 and a write to it changes nothing. Address bits 1:0 are ignored.
- R4: While running, the output pattern repeats every P = CLK_HZ*PERIOD_MS/1000 cycles.
- R5: With duty code d, each period starts with exactly floor(d*P/255) high cycles, followed by low cycles. Code 255 gives a constant high and code 0 a constant low.
- R6: If a write that sets run is sampled at clock edge k, the output after edge k+1 shows the first cycle of a new period.
- R7: If a write that clears run is sampled at edge k, the output is 0 from edge k+1 on and stays 0 while stopped. The counter is cleared, so the next start begins at the top of a period.
- R8: A duty write sampled at edge k is used from edge k+1, in the middle of the period. From the next period boundary on, only the new code sets the high time.
- R9: The mode bit and the maximum-speed field are stored only. Changing either one leaves the output waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| pwm_o | output | 1 | Fan PWM output, active high |

## Verification
Every duty code from 0 to 255 is started from a stopped state on a configuration where P is 255 cycles. For each code, the bench counts the high cycles, checks where the pulse ends, and checks that the next period starts again. This separates rounding and off-by-one faults in the scaling and the period wrap from start-up faults. A stop issued in the middle of a high phase, followed by a restart, tells a counter that is cleared apart from one that is only paused. A duty cut in the middle of a period, and writes to the mode bit and the limit word while the fan runs, show that duty changes apply at once and that the stored-only fields leave the waveform alone.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int DATA_W   = 32;
  localparam int DUTY_W   = 8;
  localparam int RPM_W    = 16;
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;

  // Field positions inside the control word
  localparam int RUN_BIT  = 0;
  localparam int MODE_BIT = 1;
  localparam int DUTY_LSB = 16;

  // Word indices (byte offset / 4)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_LIMIT = 1;

  typedef struct packed {
    logic [RPM_W-1:0]  rpm_max;
    logic [DUTY_W-1:0] duty;
    logic              mode;
    logic              run;
  } fan_cfg_t;
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output fan_cfg_t          cfg
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit_ctrl, hit_limit;

  assign idx       = addr[ADDR_W-1:2];
  assign hit_ctrl  = (idx == IDX_W'(IDX_CTRL));
  assign hit_limit = (idx == IDX_W'(IDX_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      if (hit_ctrl) begin
        cfg.run  <= wr_data[RUN_BIT];
        cfg.mode <= wr_data[MODE_BIT];
        cfg.duty <= wr_data[DUTY_LSB +: DUTY_W];
      end
      if (hit_limit) begin
        cfg.rpm_max <= wr_data[RPM_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_ctrl) begin
      rd_data[RUN_BIT]                 = cfg.run;
      rd_data[MODE_BIT]                = cfg.mode;
      rd_data[DUTY_LSB +: DUTY_W]      = cfg.duty;
    end else if (hit_limit) begin
      rd_data[RPM_W-1:0]               = cfg.rpm_max;
    end
  end

  // R3: a write to an unmapped word leaves the whole configuration unchanged
  a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_ctrl && !hit_limit) |=> $stable(cfg));

  // R2: a write elsewhere never alters the run/duty state
  a_r2_ctrl_only_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && hit_ctrl)) |=> ($stable(cfg.run) && $stable(cfg.duty) && $stable(cfg.mode)));
endmodule

// File: rtl/fan_pwm_scale.sv
module fan_pwm_scale
  import fan_pwm_pkg::*;
#(
  parameter int PCYC = 255,
  parameter int CW   = 8
) (
  input  logic [DUTY_W-1:0] duty,
  output logic [CW-1:0]     cmp
);
  localparam int PW = DUTY_W + CW;

  logic [PW-1:0] prod;

  // Constant multiply and constant divide: floor(duty * PCYC / DUTY_MAX)
  assign prod = PW'(duty) * PW'(PCYC);
  assign cmp  = CW'(prod / PW'(DUTY_MAX));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PCYC = 255,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cmp,
  output logic          pwm_o
);
  localparam logic [CW-1:0] LAST = CW'(PCYC - 1);
  localparam logic [CW-1:0] FULL = CW'(PCYC);

  logic [CW-1:0] cnt;
  logic          pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pwm_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= (cnt < cmp);
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign pwm_o = pwm_q;

  // R7: stopped means low on the following cycle
  a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_o);
  // R7: stopping discards the phase
  a_r7_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R4: the phase never leaves the period
  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R5: full-scale compare keeps the output high
  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp == FULL) |=> pwm_o);
  // R5: zero compare keeps the output low
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |=> !pwm_o);
  // R5: the scaled compare never exceeds the period
  a_r5_cmp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmp <= FULL);
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PERIOD_MS = 40,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              pwm_o
);
  localparam longint unsigned PCYC_L = (64'(CLK_HZ) * 64'(PERIOD_MS)) / 64'd1000;
  localparam int PCYC = int'(PCYC_L);
  localparam int CW   = $clog2(PCYC + 1);

  fan_cfg_t      cfg;
  logic [CW-1:0] cmp;

  fan_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cfg     (cfg)
  );

  fan_pwm_scale #(.PCYC(PCYC), .CW(CW)) u_scale (
    .duty (cfg.duty),
    .cmp  (cmp)
  );

  fan_pwm_gen #(.PCYC(PCYC), .CW(CW)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cfg.run),
    .cmp   (cmp),
    .pwm_o (pwm_o)
  );
endmodule

// File: tb/fan_pwm_ctrl_bench.sv
module fan_pwm_ctrl_bench;
  localparam int CLK_HZ    = 6375;
  localparam int PERIOD_MS = 40;
  localparam int P         = CLK_HZ * PERIOD_MS / 1000; // 255 cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fan_pwm_ctrl #(.CLK_HZ(CLK_HZ), .PERIOD_MS(PERIOD_MS), .ADDR_W(4)) u_fan_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  // Called right after a start write returns; counts one full period.
  task automatic measure(input int d);
    int exp_hi, hi;
    logic first, at_end;
    exp_hi = (d * P) / 255;
    hi = 0; first = 1'b0; at_end = 1'b0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
      if (i == 0) first = pwm_o;
      if (i == exp_hi) at_end = pwm_o;
    end
    chk("R5 high count", hi, exp_hi);
    chk("R6 first cycle of fresh period", first, exp_hi > 0);
    if (exp_hi < P) chk("R5 pulse ends on time", at_end, 1'b0);
    @(negedge clk);
    chk("R4 next period starts", pwm_o, exp_hi > 0);
  endtask

  // Wait for a rising edge of the output, then count its high run.
  task automatic pulse_after_rise(input string req, input int exp_hi);
    logic prev;
    int hi;
    bit seen;
    prev = pwm_o; seen = 0; hi = 0;
    for (int i = 0; i < 2 * P && !seen; i++) begin
      @(negedge clk);
      if (pwm_o && !prev) seen = 1;
      prev = pwm_o;
    end
    while (seen && pwm_o && hi < 2 * P) begin
      hi++;
      @(negedge clk);
    end
    chk(req, hi, exp_hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic low_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 output low in reset", pwm_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    rdchk("R1 ctrl word zero", 4'h0, 32'h0);
    rdchk("R1 limit word zero", 4'h4, 32'h0);
    chk("R1 output low after reset", pwm_o, 1'b0);

    // R2/R3 register layout (run kept 0 during these writes)
    wr(4'h0, 32'hFFFF_FFFE);
    rdchk("R2 ctrl reserved bits zero", 4'h0, 32'h00FF_0002);
    wr(4'h4, 32'hFFFF_FFFF);
    rdchk("R3 limit upper bits zero", 4'h4, 32'h0000_FFFF);
    rdchk("R3 low address bits ignored", 4'h7, 32'h0000_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0000_0000);
    rdchk("R3 unmapped reads zero", 4'h8, 32'h0);
    rdchk("R3 unmapped write ignored ctrl", 4'h0, 32'h00FF_0002);
    rdchk("R3 unmapped write ignored limit", 4'h4, 32'h0000_FFFF);
    chk("R2 stopped output low", pwm_o, 1'b0);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);

    // Exhaustive duty sweep; each stop lands mid-period, so each start checks restart (R7)
    for (int d = 0; d < 256; d++) begin
      wr(4'h0, (32'(d) << 16) | 32'h1);
      measure(d);
      wr(4'h0, 32'(d) << 16);
      @(negedge clk);
      chk("R7 low after stop", pwm_o, 1'b0);
    end

    // R7 stop during high phase, stays low, restart from the top
    wr(4'h0, (32'd200 << 16) | 32'h1);
    repeat (10) @(negedge clk);
    wr(4'h0, 32'd200 << 16);
    @(negedge clk);
    chk("R7 stop mid-high", pwm_o, 1'b0);
    low_ok = 1'b1;
    for (int i = 0; i < P + 20; i++) begin
      @(negedge clk);
      if (pwm_o) low_ok = 1'b0;
    end
    chk("R7 stays low while stopped", low_ok, 1'b1);
    wr(4'h0, (32'd200 << 16) | 32'h1);
    measure(200);

    // R8 duty cut mid-period applies at once, then alone
    wr(4'h0, 32'h0);
    wr(4'h0, (32'd100 << 16) | 32'h1);
    repeat (50) @(negedge clk);
    wr(4'h0, (32'd20 << 16) | 32'h1);
    @(negedge clk);
    chk("R8 new duty used mid-period", pwm_o, 1'b0);
    pulse_after_rise("R8 next period uses new duty", 20);

    // R9 mode bit and limit field do not change the waveform
    wr(4'h0, 32'h0);
    wr(4'h0, (32'd64 << 16) | 32'h3);
    measure(64);
    wr(4'h4, 32'h0000_1234);
    pulse_after_rise("R9 limit write no effect", 64);
    wr(4'h0, (32'd64 << 16) | 32'h1);
    pulse_after_rise("R9 mode clear no effect", 64);
    rdchk("R9 limit stored", 4'h4, 32'h0000_1234);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule